// File: doc/BRIEF.md
# Two-Point ADC Code Corrector

This block sits between a converter's sample stream and downstream logic and removes gain and offset error from every raw code. Each accepted sample is corrected with a straight-line model, the output being the raw code times a slope term plus an intercept term. The result is clamped to the legal code range. One slope/intercept pair is held for each input-range setting, and a range input on each sample picks the pair to use. A mode input either applies the full line or applies only the intercept, with the slope taken as exactly one.

Coefficients start at the identity pair after reset. They are loaded through a simple write port, which stands in for the start-up copy out of persistent storage and for later field updates. The block can also fit the line itself. A calibration request supplies the codes measured at the 20 % and 80 % reference points. A sequential divider then derives the slope, the intercept follows from it, and the new pair is committed to the chosen range. While this runs, the sample input is stalled. If the two readings do not rise, the request is refused, an error flag is raised and the stored pair stays as it was.

The fitting controller has three states. FIT_IDLE goes to FIT_DIVIDE on a start whose span is positive, and stays in FIT_IDLE, setting the error flag, when the span is not positive. FIT_DIVIDE goes to FIT_SOLVE when the divider reports done. FIT_SOLVE computes the intercept, writes the pair and returns to FIT_IDLE.

Top module: `adc_cal_engine`

## Requirements
- R1: With `two_point`=1 the output is `round(x*m/32768) + c`, with rounding half up. Here m is the 16-bit unsigned slope with 1 integer bit and 15 fraction bits, and c is the signed 16-bit intercept in code units.
- R2: With `two_point`=0 the output is `x + c`, and the stored slope is not used.
- R3: The result saturates to 0..4095 instead of wrapping.
- R4: A sample accepted at clock edge k gives `o_valid`=1 with its result after edge k+2. The block accepts one sample per cycle when it is not calibrating.
- R5: After reset `o_valid`, `cal_busy` and `cal_err` are 0 and `s_ready` is 1. Every range holds m=0x8000 and c=0, so codes pass through unchanged.
- R6: A port write at edge k affects samples accepted after edge k. A sample accepted at edge k uses the old pair in full. When a commit from the fitter lands on the same range in the same cycle, the commit wins.
- R7: `s_range` (0..3) selects the pair used for each sample, and `coef_range` and `cal_range` select the pair to be written.
- R8: A start with hi>lo writes m = min(floor(2457*32768/(hi-lo)), 65535) and c = 819 - round(m*lo/32768) to `cal_range`. The values 819 and 3276 are the ideal codes at the 20 % and 80 % points.
- R9: `cal_busy` is 1 and `s_ready` is 0 for exactly 29 cycles after an accepted start. Starts that arrive during this window are ignored.
- R10: A start with hi<=lo sets `cal_err` at the next edge. In that case `cal_busy` stays 0 and no coefficients change. A later accepted start clears `cal_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Raw sample valid |
| s_ready | output | 1 | Block accepts a sample this cycle |
| s_code | input | 12 | Raw converter code |
| s_range | input | 2 | Range setting of this sample |
| two_point | input | 1 | 1: slope and intercept; 0: intercept only |
| o_valid | output | 1 | Corrected sample valid |
| o_code | output | 12 | Corrected, saturated code |
| coef_we | input | 1 | Write one coefficient pair |
| coef_range | input | 2 | Range of the pair being written |
| coef_m | input | 16 | Slope, unsigned 1.15 |
| coef_c | input | 16 | Intercept, signed code units |
| cal_start | input | 1 | Start a two-point fit |
| cal_range | input | 2 | Range that receives the fitted pair |
| cal_meas_lo | input | 12 | Code measured at the 20 % reference |
| cal_meas_hi | input | 12 | Code measured at the 80 % reference |
| cal_busy | output | 1 | Fit in progress |
| cal_err | output | 1 | Last start was refused |

## Verification
A corrected sample is due two edges after the edge that accepts it. The bench's model pushes each expected result into a two-deep delay line and compares `o_valid` and `o_code` at the falling edge after the second edge. The model counts a fit as 29 busy cycles after the start edge and applies the fitted pair at the edge where that count reaches zero, so `s_ready` and `cal_busy` are compared cycle by cycle. Refused starts are compared one edge later through `cal_err`, and through corrected samples that still use the previous pair.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int COEF_W = 16;
    localparam int M_FRAC = 15;
    localparam logic [COEF_W-1:0] M_UNITY = COEF_W'(1) << M_FRAC;

    typedef struct packed {
        logic [COEF_W-1:0]        m;
        logic signed [COEF_W-1:0] c;
    } coef_t;

    localparam coef_t COEF_IDENT = '{m: M_UNITY, c: '0};

    typedef enum logic [1:0] {
        FIT_IDLE,
        FIT_DIVIDE,
        FIT_SOLVE
    } fit_state_e;
endpackage

// File: rtl/cal_coef_bank.sv
module cal_coef_bank
    import cal_pkg::*;
#(
    parameter int NUM_RANGES = 4,
    parameter int RSEL_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_we,
    input  logic [RSEL_W-1:0] port_sel,
    input  coef_t             port_coef,
    input  logic              fit_we,
    input  logic [RSEL_W-1:0] fit_sel,
    input  coef_t             fit_coef,
    input  logic [RSEL_W-1:0] rd_sel,
    output coef_t             rd_coef
);
    coef_t bank [NUM_RANGES];

    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank[g] <= COEF_IDENT;
            end else if (fit_we && fit_sel == RSEL_W'(g)) begin
                bank[g] <= fit_coef;
            end else if (port_we && port_sel == RSEL_W'(g)) begin
                bank[g] <= port_coef;
            end
        end

        // R6: a fitter commit is never overridden by a same-cycle port write
        assert_commit_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (fit_we && fit_sel == RSEL_W'(g)) |=> (bank[g] == $past(fit_coef)));
    end

    always_comb begin
        rd_coef = COEF_IDENT;
        for (int i = 0; i < NUM_RANGES; i++) begin
            if (rd_sel == RSEL_W'(i)) rd_coef = bank[i];
        end
    end
endmodule

// File: rtl/cal_divider.sv
module cal_divider #(
    parameter int NUM_W = 27,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] qn_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [DEN_W:0]   trial;
    logic             take;

    always_comb begin
        trial = {rem_q, qn_q[NUM_W-1]};
        take  = trial >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            qn_q  <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else if (start) begin
            rem_q <= '0;
            den_q <= den;
            qn_q  <= num;
            cnt_q <= CNT_W'(NUM_W);
            run_q <= 1'b1;
            done  <= 1'b0;
        end else if (run_q) begin
            rem_q <= take ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
            qn_q  <= {qn_q[NUM_W-2:0], take};
            cnt_q <= cnt_q - 1'b1;
            run_q <= (cnt_q != CNT_W'(1));
            done  <= (cnt_q == CNT_W'(1));
        end else begin
            done <= 1'b0;
        end
    end

    assign quot = qn_q;

    // R9: the fitter never restarts the divider while it is still iterating
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run_q);
endmodule

// File: rtl/cal_fit_fsm.sv
module cal_fit_fsm
    import cal_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int RSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_start,
    input  logic [RSEL_W-1:0] cal_sel,
    input  logic [CODE_W-1:0] meas_lo,
    input  logic [CODE_W-1:0] meas_hi,
    output logic              busy,
    output logic              err,
    output logic              wr_en,
    output logic [RSEL_W-1:0] wr_sel,
    output coef_t             wr_coef
);
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int IDEAL_LO = (CODE_MAX * 2) / 10;
    localparam int IDEAL_HI = (CODE_MAX * 8) / 10;
    localparam int NUM_W    = CODE_W + M_FRAC;
    localparam int PROD_W   = COEF_W + CODE_W;
    localparam int RND_W    = PROD_W - M_FRAC;
    localparam logic [NUM_W-1:0] FIT_NUM = NUM_W'(IDEAL_HI - IDEAL_LO) << M_FRAC;
    localparam logic [PROD_W-1:0] HALF   = PROD_W'(1) << (M_FRAC - 1);

    fit_state_e state_q, state_d;
    logic [CODE_W-1:0] lo_q;
    logic [RSEL_W-1:0] sel_q;
    logic              span_ok;
    logic              div_start;
    logic              div_done;
    logic [NUM_W-1:0]  div_quot;
    logic [COEF_W-1:0] m_sat;
    logic [PROD_W-1:0] m_lo;
    logic [RND_W-1:0]  m_lo_rnd;

    assign span_ok = meas_hi > meas_lo;

    cal_divider #(.NUM_W(NUM_W), .DEN_W(CODE_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(div_start),
        .num  (FIT_NUM),
        .den  (CODE_W'(meas_hi - meas_lo)),
        .done (div_done),
        .quot (div_quot)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FIT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        busy      = 1'b1;
        div_start = 1'b0;
        wr_en     = 1'b0;
        unique case (state_q)
            FIT_IDLE: begin
                busy = 1'b0;
                if (cal_start && span_ok) begin
                    div_start = 1'b1;
                    state_d   = FIT_DIVIDE;
                end
            end
            FIT_DIVIDE: begin
                if (div_done) state_d = FIT_SOLVE;
            end
            FIT_SOLVE: begin
                wr_en   = 1'b1;
                state_d = FIT_IDLE;
            end
            default: state_d = FIT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            sel_q <= '0;
            err   <= 1'b0;
        end else if (state_q == FIT_IDLE && cal_start) begin
            err <= !span_ok;
            if (span_ok) begin
                lo_q  <= meas_lo;
                sel_q <= cal_sel;
            end
        end
    end

    always_comb begin
        m_sat    = (div_quot[NUM_W-1:COEF_W] != '0) ? '1 : div_quot[COEF_W-1:0];
        m_lo     = PROD_W'(m_sat) * PROD_W'(lo_q);
        m_lo_rnd = RND_W'((m_lo + HALF) >> M_FRAC);
        wr_coef.m = m_sat;
        wr_coef.c = COEF_W'(IDEAL_LO) - COEF_W'(m_lo_rnd);
        wr_sel    = sel_q;
    end

    // R10: the error flag only rises after a start with a non-rising span
    assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(cal_start && !span_ok && state_q == FIT_IDLE));
    // R8: a commit follows the divider's completion by exactly one cycle
    assert_commit_after_quot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(div_done));
    // R10: a refused start never makes the fitter busy
    assert_refused_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FIT_IDLE && cal_start && !span_ok) |=> !busy);
endmodule

// File: rtl/cal_correct_pipe.sv
module cal_correct_pipe
    import cal_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [CODE_W-1:0]        in_code,
    input  logic [COEF_W-1:0]        in_m,
    input  logic signed [COEF_W-1:0] in_c,
    output logic                     o_valid,
    output logic [CODE_W-1:0]        o_code
);
    localparam int PROD_W   = CODE_W + COEF_W;
    localparam int RND_W    = PROD_W - M_FRAC;
    localparam int SUM_W    = ((RND_W > COEF_W) ? RND_W : COEF_W) + 2;
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (M_FRAC - 1);

    logic                     v1_q;
    logic [RND_W-1:0]         p1_q;
    logic signed [COEF_W-1:0] c1_q;
    logic [PROD_W-1:0]        prod;
    logic signed [SUM_W-1:0]  sum;
    logic                     sum_neg;
    logic                     sum_high;

    assign prod = PROD_W'(in_code) * PROD_W'(in_m);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            p1_q <= '0;
            c1_q <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) begin
                p1_q <= RND_W'((prod + HALF) >> M_FRAC);
                c1_q <= in_c;
            end
        end
    end

    always_comb begin
        sum      = SUM_W'(p1_q) + SUM_W'(c1_q);
        sum_neg  = sum[SUM_W-1];
        sum_high = !sum_neg && (sum > SUM_W'(CODE_MAX));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_code  <= '0;
        end else begin
            o_valid <= v1_q;
            if (v1_q) begin
                if (sum_neg)       o_code <= '0;
                else if (sum_high) o_code <= CODE_W'(CODE_MAX);
                else               o_code <= sum[CODE_W-1:0];
            end
        end
    end

    // R4: every accepted sample appears two edges later
    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 o_valid);
    // R3: negative sums clamp to zero
    assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_q && sum_neg) |=> (o_code == '0));
    // R3: sums above full scale clamp to the top code
    assert_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (v1_q && sum_high) |=> (o_code == CODE_W'(CODE_MAX)));
endmodule

// File: rtl/adc_cal_engine.sv
module adc_cal_engine
    import cal_pkg::*;
#(
    parameter int CODE_W     = 12,
    parameter int NUM_RANGES = 4,
    parameter int RSEL_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [CODE_W-1:0] s_code,
    input  logic [RSEL_W-1:0] s_range,
    input  logic              two_point,
    output logic              o_valid,
    output logic [CODE_W-1:0] o_code,
    input  logic              coef_we,
    input  logic [RSEL_W-1:0] coef_range,
    input  logic [COEF_W-1:0] coef_m,
    input  logic [COEF_W-1:0] coef_c,
    input  logic              cal_start,
    input  logic [RSEL_W-1:0] cal_range,
    input  logic [CODE_W-1:0] cal_meas_lo,
    input  logic [CODE_W-1:0] cal_meas_hi,
    output logic              cal_busy,
    output logic              cal_err
);
    coef_t       port_coef;
    coef_t       fit_coef;
    coef_t       rd_coef;
    logic        fit_we;
    logic [RSEL_W-1:0] fit_sel;
    logic        accept;
    logic [COEF_W-1:0] m_eff;

    assign port_coef = '{m: coef_m, c: coef_c};

    cal_fit_fsm #(.CODE_W(CODE_W), .RSEL_W(RSEL_W)) u_fit (
        .clk      (clk),
        .rst_n    (rst_n),
        .cal_start(cal_start),
        .cal_sel  (cal_range),
        .meas_lo  (cal_meas_lo),
        .meas_hi  (cal_meas_hi),
        .busy     (cal_busy),
        .err      (cal_err),
        .wr_en    (fit_we),
        .wr_sel   (fit_sel),
        .wr_coef  (fit_coef)
    );

    cal_coef_bank #(.NUM_RANGES(NUM_RANGES), .RSEL_W(RSEL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_we  (coef_we),
        .port_sel (coef_range),
        .port_coef(port_coef),
        .fit_we   (fit_we),
        .fit_sel  (fit_sel),
        .fit_coef (fit_coef),
        .rd_sel   (s_range),
        .rd_coef  (rd_coef)
    );

    assign s_ready = !cal_busy;
    assign accept  = s_valid && s_ready;
    assign m_eff   = two_point ? rd_coef.m : M_UNITY;

    cal_correct_pipe #(.CODE_W(CODE_W)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(accept),
        .in_code (s_code),
        .in_m    (m_eff),
        .in_c    (rd_coef.c),
        .o_valid (o_valid),
        .o_code  (o_code)
    );

    // R9: no result can come out of a sample offered while the fitter was busy
    assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && cal_busy) |=> ##1 !o_valid);
endmodule

// File: tb/tb_adc_cal_engine.sv
module tb_adc_cal_engine;
    localparam int CAL_CYC = 29;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [11:0] s_code = '0;
    logic [1:0]  s_range = '0;
    logic        two_point = 1'b1;
    logic        o_valid;
    logic [11:0] o_code;
    logic        coef_we = 1'b0;
    logic [1:0]  coef_range = '0;
    logic [15:0] coef_m = '0;
    logic [15:0] coef_c = '0;
    logic        cal_start = 1'b0;
    logic [1:0]  cal_range = '0;
    logic [11:0] cal_meas_lo = '0;
    logic [11:0] cal_meas_hi = '0;
    logic        cal_busy;
    logic        cal_err;

    always #4 clk = ~clk;

    adc_cal_engine dut (
        .clk(clk), .rst_n(rst_n),
        .s_valid(s_valid), .s_ready(s_ready), .s_code(s_code), .s_range(s_range),
        .two_point(two_point), .o_valid(o_valid), .o_code(o_code),
        .coef_we(coef_we), .coef_range(coef_range), .coef_m(coef_m), .coef_c(coef_c),
        .cal_start(cal_start), .cal_range(cal_range),
        .cal_meas_lo(cal_meas_lo), .cal_meas_hi(cal_meas_hi),
        .cal_busy(cal_busy), .cal_err(cal_err)
    );

    int vectors = 0;
    int miscompares = 0;

    // behavioural model state
    longint mdl_m [4];
    longint mdl_c [4];
    int     busy_left = 0;
    bit     err_m = 0;
    longint pend_m, pend_c;
    int     pend_sel;
    bit     p1_v = 0, p2_v = 0;
    longint p1_e = 0, p2_e = 0;
    string  p1_r = "R4", p2_r = "R4";
    string  cur_req = "R5";

    task automatic chk(string req, string what, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic longint correct(longint x, longint m, longint c, bit tp);
        longint y;
        if (tp) y = ((x * m + 16384) >>> 15) + c;
        else    y = x + c;
        if (y < 0) y = 0;
        if (y > 4095) y = 4095;
        return y;
    endfunction

    task automatic tick();
        bit     rdy, acc, commit;
        longint e;
        longint span;
        rdy = (busy_left == 0);
        acc = s_valid && rdy;
        e = correct(longint'(s_code), mdl_m[s_range], mdl_c[s_range], two_point);
        commit = 0;
        @(posedge clk);
        p2_v = p1_v; p2_e = p1_e; p2_r = p1_r;
        p1_v = acc;  p1_e = e;    p1_r = cur_req;
        if (cal_start && rdy) begin
            if (cal_meas_hi > cal_meas_lo) begin
                span = longint'(cal_meas_hi) - longint'(cal_meas_lo);
                pend_m = (longint'(2457) * 32768) / span;
                if (pend_m > 65535) pend_m = 65535;
                pend_c = 819 - ((pend_m * longint'(cal_meas_lo) + 16384) >>> 15);
                pend_sel = int'(cal_range);
                busy_left = CAL_CYC;
                err_m = 0;
            end else begin
                err_m = 1;
            end
        end else if (busy_left > 0) begin
            busy_left--;
            commit = (busy_left == 0);
        end
        if (coef_we) begin
            mdl_m[coef_range] = longint'(coef_m);
            mdl_c[coef_range] = longint'($signed(coef_c));
        end
        if (commit) begin
            mdl_m[pend_sel] = pend_m;
            mdl_c[pend_sel] = pend_c;
        end
        @(negedge clk);
        chk("R9", "s_ready", s_ready, busy_left == 0);
        chk("R9", "cal_busy", cal_busy, busy_left != 0);
        chk("R10", "cal_err", cal_err, err_m);
        chk(p2_r, "o_valid", o_valid, p2_v);
        if (p2_v && o_valid) chk(p2_r, "o_code", o_code, p2_e);
    endtask

    task automatic wr(int r, int m, int c);
        coef_we = 1; coef_range = 2'(r); coef_m = 16'(m); coef_c = 16'(c);
    endtask

    task automatic stream(int n, int r, int seed);
        s_valid = 1; s_range = 2'(r);
        for (int i = 0; i < n; i++) begin
            s_code = 12'((i * 397 + seed) % 4096);
            tick();
        end
        s_valid = 0;
    endtask

    initial begin
        #(8 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin mdl_m[i] = 32768; mdl_c[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R5: reset state
        chk("R5", "o_valid", o_valid, 0);
        chk("R5", "cal_busy", cal_busy, 0);
        chk("R5", "cal_err", cal_err, 0);
        chk("R5", "s_ready", s_ready, 1);
        cur_req = "R5";
        s_valid = 1; s_code = 12'd1234; s_range = 0; tick();
        s_code = 12'd4095; s_range = 3; tick();
        s_valid = 0; tick(); tick();

        // R1: full line on range 1, back-to-back samples
        wr(1, 'h9000, -20); tick(); coef_we = 0;
        cur_req = "R1";
        stream(10, 1, 13);
        // R2: intercept only
        cur_req = "R2";
        two_point = 0;
        stream(6, 1, 700);
        s_valid = 1; s_code = 12'd5; tick(); s_valid = 0;
        two_point = 1;
        tick(); tick();

        // R3: saturation at both ends
        wr(2, 'hFFFF, 100); tick();
        wr(3, 'h4000, -500); tick(); coef_we = 0;
        cur_req = "R3";
        s_valid = 1; s_range = 2;
        s_code = 12'd4095; tick(); s_code = 12'd3000; tick(); s_code = 12'd1000; tick();
        s_range = 3; s_code = 12'd10; tick(); s_code = 12'd900; tick(); s_code = 12'd4095; tick();
        s_valid = 0; tick(); tick();

        // R7: alternating ranges per sample
        cur_req = "R7";
        s_valid = 1;
        for (int i = 0; i < 12; i++) begin
            s_range = 2'(i % 4); s_code = 12'((i * 331 + 77) % 4096); tick();
        end
        s_valid = 0; tick(); tick();

        // R6: write in the same cycle as a sample, continuous stream
        cur_req = "R6";
        s_valid = 1; s_range = 1;
        for (int i = 0; i < 8; i++) begin
            s_code = 12'(i * 500 + 3);
            if (i == 3) wr(1, 'h7000, 45);
            else if (i == 5) wr(1, 'h8800, -7);
            else coef_we = 0;
            tick();
        end
        coef_we = 0; s_valid = 0; tick(); tick();

        // R8 and R9: fit range 0 while samples are offered; a second start is ignored
        cur_req = "R9";
        s_valid = 1; s_range = 0; s_code = 12'd2000;
        cal_start = 1; cal_range = 0; cal_meas_lo = 12'd800; cal_meas_hi = 12'd3300;
        tick();
        cal_start = 0;
        for (int i = 0; i < 10; i++) tick();
        cal_start = 1; cal_meas_lo = 12'd0; cal_meas_hi = 12'd4000; tick();
        cal_start = 0;
        for (int i = 0; i < 20; i++) tick();
        cur_req = "R8";
        stream(8, 0, 500);
        tick(); tick();

        // R10: refused starts keep the previous pair
        cal_start = 1; cal_range = 0; cal_meas_lo = 12'd2000; cal_meas_hi = 12'd2000; tick();
        cal_start = 0;
        cur_req = "R10";
        stream(4, 0, 91);
        cal_start = 1; cal_meas_lo = 12'd3000; cal_meas_hi = 12'd100; tick();
        cal_start = 0;
        stream(4, 0, 1900);
        tick(); tick();

        // R8: short span saturates the slope; the accepted start clears the error (R10)
        cal_start = 1; cal_range = 3; cal_meas_lo = 12'd1000; cal_meas_hi = 12'd1500; tick();
        cal_start = 0;
        for (int i = 0; i < CAL_CYC + 2; i++) tick();
        cur_req = "R8";
        stream(6, 3, 1100);
        tick(); tick(); tick();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule